// File: doc/BRIEF.md
# FEAC Codeword Transmit Sequencer

This block produces the serial bit stream for far-end alarm and control signalling on a DS3-style line. Each codeword is 16 bits long: a run of eight ones, a zero, six data bits with the least significant bit first, and a closing zero. When no action is running, the line carries an unbroken all-ones pattern. The framer presents one transmit slot at a time on `tx_en`. The block moves forward by one bit only in a cycle where that strobe is high.

A host register supplies two 6-bit codewords (A and B) and a 2-bit action select. An action starts on an edge of the select: the select must be seen at the null value before a non-null value can start anything. Both data words are captured in the cycle the action starts. The sequencer has five named states:

- `ST_IDLE`: sends all ones.
- `ST_A_ONLY`: a burst of ten A codewords.
- `ST_A_THEN_B`: ten A codewords, then moves to `ST_B_TAIL`.
- `ST_B_TAIL`: ten B codewords.
- `ST_A_LOOP`: A codewords repeated for as long as the select holds at 11, with at least ten sent.

The transitions are:

- Start: `ST_IDLE` goes to one of the sending states.
- Burst done: `ST_A_ONLY` or `ST_B_TAIL` returns to `ST_IDLE`.
- Hand-over: `ST_A_THEN_B` goes to `ST_B_TAIL`.
- Loop exit: `ST_A_LOOP` returns to `ST_IDLE`.

Every transition out of a sending state happens only on the last bit of a codeword.

Top module: `feac_tx_seq`

## Requirements
- R1: Each codeword is sent as 16 bits in this order: eight ones, one zero, six data bits, one zero. A codeword in progress always completes all 16 bits.
- R2: The six data bits go out least significant first: bit 0 of the data word comes right after the first zero, and bit 5 comes just before the closing zero.
- R3: While no action is running, `tx_bit` is 1 and `busy` is 0.
- R4: Select code 01 sends codeword A ten times, then returns to all ones.
- R5: Select code 10 sends codeword A ten times, then codeword B ten times, then all ones.
- R6: Select code 11 keeps sending codeword A while the select stays 11. It sends at least ten A codewords in total, even if the select leaves 11 earlier. After the select leaves 11, the current codeword is finished before the block goes idle.
- R7: An action starts only when the block is idle, the select is non-zero, and the select has been sampled at 00 since the previous start. Changing the select directly from one non-zero code to another starts nothing.
- R8: Both data words are captured when an action starts. Changing `code_a` or `code_b` during the action has no effect on the bits sent.
- R9: The bit position moves forward only on a clock edge where `tx_en` is high. `busy` rises in the cycle after the start edge and falls right after the final bit of the final codeword is consumed.
- R10: A synchronous reset (`rst` high at a clock edge) gives `ST_IDLE`, a zero repeat count, `tx_bit` = 1, `busy` = 0, and requires a fresh 00 on the select before the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit slot strobe; one bit is consumed per high cycle |
| sel | input | 2 | Action select: 00 null, 01 ten A, 10 ten A then ten B, 11 A looped |
| code_a | input | DATA_W | Data bits of codeword A |
| code_b | input | DATA_W | Data bits of codeword B |
| tx_bit | output | 1 | Serial output bit for the current slot |
| busy | output | 1 | High while an action is being sent |

## Verification
The bench uses the default parameters: eight preamble ones, six data bits and ten repeats. With these values a full two-burst action takes only 320 strobes, so every mode runs to completion, including the hand-over from A to B and the loop exit both before and after the tenth codeword. The strobe is sent at several duty ratios. This shows that bits hold between strobes and that `busy` falls exactly on the last consumed bit. Scenarios that change the select directly, edit the data words mid-action and reset mid-action cover the edge-start and capture rules.

// File: rtl/feac_pkg.sv
package feac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_A_ONLY,
        ST_A_THEN_B,
        ST_B_TAIL,
        ST_A_LOOP
    } feac_state_e;

    localparam logic [1:0] SEL_NULL  = 2'b00;
    localparam logic [1:0] SEL_A10   = 2'b01;
    localparam logic [1:0] SEL_AB10  = 2'b10;
    localparam logic [1:0] SEL_ALOOP = 2'b11;

endpackage

// File: rtl/feac_start_gate.sv
// Edge-start gate: a non-null select starts an action only after 00 was seen (R7).
module feac_start_gate (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel_i,
    input  logic       idle_i,
    output logic       start_o
);
    import feac_pkg::*;

    logic armed_q;

    always_comb begin
        start_o = idle_i && armed_q && (sel_i != SEL_NULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;            // R10: reset needs a fresh null
        end else if (sel_i == SEL_NULL) begin
            armed_q <= 1'b1;
        end else if (start_o) begin
            armed_q <= 1'b0;
        end
    end

endmodule

// File: rtl/feac_cw_serializer.sv
// Bit position counter and codeword bit select (R1, R2).
module feac_cw_serializer #(
    parameter int DATA_W   = 6,
    parameter int PRE_ONES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              adv_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              bit_o,
    output logic              last_o
);
    localparam int CW_LEN  = PRE_ONES + DATA_W + 2;
    localparam int IDX_W   = $clog2(CW_LEN);
    localparam int DSEL_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int DATA_LO = PRE_ONES + 1;
    localparam int DATA_HI = PRE_ONES + DATA_W;

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] rel;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            idx_q <= '0;
        end else if (adv_i) begin
            if (last_o) idx_q <= '0;
            else        idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        last_o = (idx_q == IDX_W'(CW_LEN - 1));
        rel    = idx_q - IDX_W'(DATA_LO);
        if (idx_q < IDX_W'(PRE_ONES)) begin
            bit_o = 1'b1;
        end else if (idx_q >= IDX_W'(DATA_LO) && idx_q <= IDX_W'(DATA_HI)) begin
            bit_o = data_i[rel[DSEL_W-1:0]];
        end else begin
            bit_o = 1'b0;
        end
    end

endmodule

// File: rtl/feac_rep_cnt.sv
// Saturating codeword repeat counter.
module feac_rep_cnt #(
    parameter int REPS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic done_o
);
    localparam int CNT_W = (REPS > 1) ? $clog2(REPS) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        done_o = (cnt_q == CNT_W'(REPS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && !done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/feac_tx_seq.sv
module feac_tx_seq #(
    parameter int DATA_W   = 6,
    parameter int PRE_ONES = 8,
    parameter int REPS     = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] code_a,
    input  logic [DATA_W-1:0] code_b,
    output logic              tx_bit,
    output logic              busy
);
    import feac_pkg::*;

    feac_state_e       state_q, state_d;
    logic [DATA_W-1:0] a_q, b_q, cur_data;
    logic              start, ser_bit, last_bit, word_end, rep_done, rep_clr;

    feac_start_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (sel),
        .idle_i  (state_q == ST_IDLE),
        .start_o (start)
    );

    feac_cw_serializer #(.DATA_W(DATA_W), .PRE_ONES(PRE_ONES)) u_ser (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (start),
        .adv_i  (busy && tx_en),          // R9
        .data_i (cur_data),
        .bit_o  (ser_bit),
        .last_o (last_bit)
    );

    feac_rep_cnt #(.REPS(REPS)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (rep_clr),
        .inc_i  (word_end),
        .done_o (rep_done)
    );

    // Data capture at action start (R8)
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (start) begin
            a_q <= code_a;
            b_q <= code_b;
        end
    end

    always_comb begin
        cur_data = (state_q == ST_B_TAIL) ? b_q : a_q;
        word_end = busy && tx_en && last_bit;
        rep_clr  = start || (state_q == ST_A_THEN_B && word_end && rep_done);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    unique case (sel)
                        SEL_A10:  state_d = ST_A_ONLY;
                        SEL_AB10: state_d = ST_A_THEN_B;
                        default:  state_d = ST_A_LOOP;
                    endcase
                end
            end
            ST_A_ONLY:   if (word_end && rep_done) state_d = ST_IDLE;      // R4
            ST_A_THEN_B: if (word_end && rep_done) state_d = ST_B_TAIL;    // R5
            ST_B_TAIL:   if (word_end && rep_done) state_d = ST_IDLE;      // R5
            ST_A_LOOP:   if (word_end && rep_done && sel != SEL_ALOOP)
                             state_d = ST_IDLE;                            // R6
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;    // R10
        else     state_q <= state_d;
    end

    // Outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        tx_bit = busy ? ser_bit : 1'b1; // R3
    end

endmodule

// File: rtl/feac_tx_seq_chk.sv
module feac_tx_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_en,
    input logic [1:0] sel,
    input logic       tx_bit,
    input logic       busy
);
    assert_idle_ones_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_bit);

    assert_hold_without_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !tx_en) |=> (busy && $stable(tx_bit)));

    assert_start_from_nonnull_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(sel) != 2'b00));

    assert_end_on_closing_zero_R1: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> ($past(tx_en) && !$past(tx_bit)));

    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (!busy && tx_bit));
endmodule

bind feac_tx_seq feac_tx_seq_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .tx_en  (tx_en),
    .sel    (sel),
    .tx_bit (tx_bit),
    .busy   (busy)
);

// File: tb/sim_feac_tx_seq.sv
module sim_feac_tx_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic [1:0] sel = 2'b00;
    logic [5:0] code_a = '0, code_b = '0;
    logic       tx_bit, busy;

    int    checks = 0, failures = 0, cyc = 0, ten_period = 1;
    string cur_req = "R10";

    bit q[$];
    bit m_armed = 0, m_loop = 0;

    always #4 clk = ~clk;

    feac_tx_seq u0 (.clk(clk), .rst(rst), .tx_en(tx_en), .sel(sel),
                    .code_a(code_a), .code_b(code_b), .tx_bit(tx_bit), .busy(busy));

    task automatic push_word(input logic [5:0] d);
        for (int i = 0; i < 8; i++) q.push_back(1'b1);
        q.push_back(1'b0);
        for (int i = 0; i < 6; i++) q.push_back(d[i]);
        q.push_back(1'b0);
    endtask

    // Behavioural reference: queue of pending line bits
    always @(posedge clk) begin
        bit started;
        started = 0;
        if (rst) begin
            q.delete(); m_armed = 0; m_loop = 0;
        end else begin
            if (q.size() != 0) begin
                if (tx_en) begin
                    void'(q.pop_front());
                    if (q.size() == 0 && m_loop && sel == 2'b11) push_word(code_a_cap);
                end
            end else if (m_armed && sel != 2'b00) begin
                started = 1;
                code_a_cap = code_a; code_b_cap = code_b;
                m_loop = (sel == 2'b11);
                for (int k = 0; k < 10; k++) push_word(code_a);
                if (sel == 2'b10) for (int k = 0; k < 10; k++) push_word(code_b);
            end
            if (sel == 2'b00) m_armed = 1;
            else if (started) m_armed = 0;
        end
    end
    logic [5:0] code_a_cap = '0, code_b_cap = '0;

    task automatic tick();
        bit eb, ebusy;
        @(negedge clk);
        cyc++;
        eb    = (q.size() != 0) ? q[0] : 1'b1;
        ebusy = (q.size() != 0);
        checks++;
        if (tx_bit !== eb || busy !== ebusy) begin
            failures++;
            $display("FAIL %s cyc=%0d tx_bit=%b busy=%b expected tx_bit=%b busy=%b",
                     cur_req, cyc, tx_bit, busy, eb, ebusy);
        end
        tx_en = ((cyc % ten_period) == 0);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic run_to_idle();
        for (int i = 0; i < 4000 && q.size() != 0; i++) tick();
        run(5);
    endtask

    task automatic direct_check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10: reset state
        run(3);
        direct_check("R10 busy", busy, 1'b0);
        direct_check("R10 tx_bit", tx_bit, 1'b1);
        rst = 1'b0;

        // R3: idle all ones under toggling strobe
        cur_req = "R3"; ten_period = 2;
        run(40);

        // R4 with R1/R2 framing, strobe every cycle
        cur_req = "R4_R1_R2"; ten_period = 1; code_a = 6'b101101; code_b = 6'b010010;
        sel = 2'b01; run(2);
        direct_check("R9 busy after start", busy, 1'b1);
        run_to_idle();

        // R7: direct 01 -> 10 starts nothing
        cur_req = "R7"; sel = 2'b10; run(30);
        direct_check("R7 no start", busy, 1'b0);

        // R5 + R8 + R9: A then B, strobe 1 of 3, data edited mid-action
        cur_req = "R5_R8_R9"; ten_period = 3; code_a = 6'b000001; code_b = 6'b100000;
        sel = 2'b00; run(4); sel = 2'b10; run(200);
        code_a = 6'b111111; code_b = 6'b000000;
        run_to_idle();

        // R6: loop held long, then released
        cur_req = "R6_long"; ten_period = 2; code_a = 6'b110010;
        sel = 2'b00; run(3); sel = 2'b11; run(16 * 2 * 14 + 5);
        sel = 2'b00; run_to_idle();

        // R6: loop released early still sends ten
        cur_req = "R6_min"; ten_period = 1; code_a = 6'b011001;
        sel = 2'b11; run(40); sel = 2'b00; run_to_idle();

        // R9: irregular strobe
        cur_req = "R9"; ten_period = 5; code_a = 6'b100110;
        sel = 2'b01; run_to_idle();

        // R10: reset mid-action and re-arm requirement
        cur_req = "R10"; ten_period = 1; sel = 2'b00; run(2); sel = 2'b10; run(50);
        rst = 1'b1; run(2); rst = 1'b0; run(20);
        direct_check("R10 no restart without null", busy, 1'b0);
        sel = 2'b00; run(2); sel = 2'b01; run_to_idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule